// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Compare

This block is a purely combinational integer arithmetic logic unit. A row of identical one-bit cells, chained through a ripple carry, forms the datapath. A three-bit operation code picks one of five functions: bitwise AND, bitwise OR, addition, subtraction, and a signed less-than compare that returns 0 or 1. Besides the result word, the block drives a flag that is set when the result is all zeros. It also drives a signed overflow flag for add and subtract.

For subtraction, the upper bit of the operation code inverts operand B in every cell and also feeds the carry into the lowest cell. The adder then computes A + ~B + 1. For the compare, the cells run that same subtraction. The sign of the difference is taken from the top cell, corrected by the overflow of the subtraction, and routed back to the lowest cell as its compare input. The compare input of every other cell is tied to zero. To test two operands for equality, subtract them and read the zero flag. Codes outside the five listed ones produce an all-zero result.

Top module: `alu_ripple`

## Requirements
- R1: Code 3'b000 makes the result the bitwise AND of A and B.
- R2: Code 3'b001 makes the result the bitwise OR of A and B.
- R3: Code 3'b010 makes the result A + B modulo 2^WIDTH.
- R4: Code 3'b110 makes the result A - B modulo 2^WIDTH (A + ~B + 1).
- R5: Code 3'b111 makes the result 1 when A is less than B read as two's-complement numbers, and 0 otherwise. All upper bits are 0, and the answer stays correct when A - B overflows.
- R6: The zero flag is 1 exactly when every result bit is 0. Under code 3'b110 it is therefore 1 exactly when A equals B.
- R7: Under code 3'b010 the overflow flag is 1 exactly when A and B have the same sign bit and the sign bit of the result differs from it.
- R8: Under code 3'b110 the overflow flag is 1 exactly when A and B have different sign bits and the sign bit of the result differs from that of A.
- R9: Under codes 3'b000, 3'b001 and 3'b111 the overflow flag is 0.
- R10: Codes 3'b011, 3'b100 and 3'b101 give an all-zero result, overflow 0 and zero flag 1.
- R11: The outputs depend only on the present inputs. There is no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| op_i | input | 3 | Operation code |
| result_o | output | WIDTH | Result word |
| zero_o | output | 1 | High when the result is all zeros |
| overflow_o | output | 1 | Signed overflow of add or subtract |

## Verification
The bench builds two copies of the block. The first uses the default WIDTH of 32. Directed vectors drive it to the signed extremes, to carries that run through all 32 cells, and to compares where the subtraction overflows. The second copy uses WIDTH set to 6. That is narrow enough to apply every operand pair under all eight operation codes. Every sign combination, every overflow case, and every code outside the listed set is therefore checked against a model built from the requirements, not only the chosen cases.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  // cell output select, low two code bits
  localparam logic [1:0] SEL_AND  = 2'b00;
  localparam logic [1:0] SEL_OR   = 2'b01;
  localparam logic [1:0] SEL_SUM  = 2'b10;
  localparam logic [1:0] SEL_LESS = 2'b11;
endpackage

// File: rtl/alu_cell.sv
module alu_cell
  import alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       binv_i,
  input  logic       cin_i,
  input  logic       less_i,
  input  logic [1:0] sel_i,
  output logic       res_o,
  output logic       sum_o,
  output logic       cout_o
);
  logic b_eff;

  always_comb begin
    b_eff  = b_i ^ binv_i;
    sum_o  = a_i ^ b_eff ^ cin_i;
    cout_o = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);
    unique case (sel_i)
      SEL_AND:  res_o = a_i & b_eff;
      SEL_OR:   res_o = a_i | b_eff;
      SEL_SUM:  res_o = sum_o;
      default:  res_o = less_i;
    endcase
  end
endmodule

// File: rtl/alu_sign_ctl.sv
module alu_sign_ctl (
  input  logic a_msb_i,
  input  logic b_msb_i,
  input  logic binv_i,
  input  logic sum_msb_i,
  input  logic c_into_msb_i,
  input  logic c_out_msb_i,
  output logic ovf_o,
  output logic set_o
);
  always_comb begin
    ovf_o = c_into_msb_i ^ c_out_msb_i;
    set_o = sum_msb_i ^ ovf_o;  // true sign of A-B even on overflow
  end

  // R7/R8: carry-based detector agrees with the operand-sign rule
  always_comb begin
    if (!$isunknown({a_msb_i, b_msb_i, binv_i, sum_msb_i, c_into_msb_i, c_out_msb_i})) begin
      if (binv_i) begin
        p_sub_sign_rule_r8: assert (ovf_o == ((a_msb_i != b_msb_i) && (sum_msb_i != a_msb_i)))
          else $error("R8 subtract overflow mismatch");
      end else begin
        p_add_sign_rule_r7: assert (ovf_o == ((a_msb_i == b_msb_i) && (sum_msb_i != a_msb_i)))
          else $error("R7 add overflow mismatch");
      end
    end
  end
endmodule

// File: rtl/alu_out_stage.sv
module alu_out_stage
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] chain_res_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic             ovf_raw_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             overflow_o
);
  logic legal;
  logic arith;

  always_comb begin
    legal = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_ADD) ||
            (op_i == OP_SUB) || (op_i == OP_SLT);
    arith = (op_i == OP_ADD) || (op_i == OP_SUB);
    result_o   = legal ? chain_res_i : '0;
    overflow_o = arith & ovf_raw_i;
    zero_o     = ~|result_o;
  end

  always_comb begin
    if (!$isunknown({op_i, ovf_raw_i, chain_res_i})) begin
      if (!legal) begin
        p_illegal_quiet_r10: assert (zero_o && !overflow_o)
          else $error("R10 unlisted code not quiet");
      end
      if (op_i == OP_AND || op_i == OP_OR || op_i == OP_SLT) begin
        p_no_overflow_r9: assert (!overflow_o)
          else $error("R9 overflow outside add/sub");
      end
    end
  end
endmodule

// File: rtl/alu_ripple.sv
module alu_ripple
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             overflow_o
);
  localparam int MSB = WIDTH - 1;

  logic             binv;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] less;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] chain_res;
  logic             ovf_raw;
  logic             set_bit;

  assign binv     = op_i[OP_W-1];
  assign carry[0] = binv;
  assign less     = {{(WIDTH-1){1'b0}}, set_bit};

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    alu_cell u_cell (
      .a_i    (a_i[i]),
      .b_i    (b_i[i]),
      .binv_i (binv),
      .cin_i  (carry[i]),
      .less_i (less[i]),
      .sel_i  (op_i[1:0]),
      .res_o  (chain_res[i]),
      .sum_o  (sum[i]),
      .cout_o (carry[i+1])
    );
  end

  alu_sign_ctl u_sign (
    .a_msb_i      (a_i[MSB]),
    .b_msb_i      (b_i[MSB]),
    .binv_i       (binv),
    .sum_msb_i    (sum[MSB]),
    .c_into_msb_i (carry[MSB]),
    .c_out_msb_i  (carry[WIDTH]),
    .ovf_o        (ovf_raw),
    .set_o        (set_bit)
  );

  alu_out_stage #(.WIDTH(WIDTH)) u_out (
    .chain_res_i (chain_res),
    .op_i        (op_i),
    .ovf_raw_i   (ovf_raw),
    .result_o    (result_o),
    .zero_o      (zero_o),
    .overflow_o  (overflow_o)
  );

  always_comb begin
    if (!$isunknown({a_i, b_i, op_i})) begin
      if (op_i == OP_ADD) begin
        p_add_value_r3: assert (result_o == a_i + b_i && sum == a_i + b_i)
          else $error("R3 add result mismatch");
      end
      if (op_i == OP_SUB) begin
        p_sub_value_r4: assert (result_o == a_i - b_i)
          else $error("R4 subtract result mismatch");
        p_equal_zero_r6: assert (zero_o == (a_i == b_i))
          else $error("R6 equality via zero flag mismatch");
      end
      if (op_i == OP_SLT) begin
        p_slt_value_r5: assert (result_o == WIDTH'($signed(a_i) < $signed(b_i)))
          else $error("R5 compare mismatch");
      end
    end
  end
endmodule

// File: tb/tb_alu_ripple.sv
module tb_alu_ripple;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 32;
  localparam int NW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0]  a, b, res;
  logic [2:0]    op;
  logic          zero, ovf;
  logic [NW-1:0] na, nb, nres;
  logic [2:0]    nop;
  logic          nzero, novf;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  alu_ripple #(.WIDTH(W)) dut (
    .a_i(a), .b_i(b), .op_i(op),
    .result_o(res), .zero_o(zero), .overflow_o(ovf)
  );

  alu_ripple #(.WIDTH(NW)) dut_narrow (
    .a_i(na), .b_i(nb), .op_i(nop),
    .result_o(nres), .zero_o(nzero), .overflow_o(novf)
  );

  // reference built from the requirement text
  function automatic void model(input int n, input logic [2:0] o,
                                input longint ua, input longint ub,
                                output longint r, output logic v);
    longint mask = (longint'(1) << n) - 1;
    longint sa = ((ua >> (n-1)) & 1) != 0 ? ua - (longint'(1) << n) : ua;
    longint sb = ((ub >> (n-1)) & 1) != 0 ? ub - (longint'(1) << n) : ub;
    longint sgn_a = (ua >> (n-1)) & 1;
    longint sgn_b = (ub >> (n-1)) & 1;
    longint sgn_r;
    v = 1'b0;
    case (o)
      3'b000: r = ua & ub;
      3'b001: r = ua | ub;
      3'b010: begin
        r = (ua + ub) & mask;
        sgn_r = (r >> (n-1)) & 1;
        v = (sgn_a == sgn_b) && (sgn_r != sgn_a);
      end
      3'b110: begin
        r = (ua - ub) & mask;
        sgn_r = (r >> (n-1)) & 1;
        v = (sgn_a != sgn_b) && (sgn_r != sgn_a);
      end
      3'b111: r = (sa < sb) ? 1 : 0;
      default: r = 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3/R7";
      3'b110: return "R4/R8";
      3'b111: return "R5/R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check32(input logic [2:0] o, input logic [W-1:0] x,
                         input logic [W-1:0] y, input string tag);
    longint er;
    logic   ev;
    @(negedge clk);
    op = o; a = x; b = y;
    #1;
    model(W, o, longint'(x), longint'(y), er, ev);
    checks++;
    if (res !== W'(er) || ovf !== ev || zero !== (er == 0)) begin
      fails++;
      $display("FAIL %s op=%b a=%h b=%h: got res=%h ovf=%b zero=%b exp res=%h ovf=%b zero=%b",
               tag, o, x, y, res, ovf, zero, W'(er), ev, (er == 0));
    end
  endtask

  task automatic t_reset_state;
    @(posedge rst_n);
    check32(3'b000, '0, '0, "R6 idle");
  endtask

  task automatic t_logic;
    check32(3'b000, 32'hF0F0_1234, 32'h0FF0_FFFF, "R1");
    check32(3'b000, 32'hFFFF_FFFF, 32'h8000_0001, "R1");
    check32(3'b001, 32'hF0F0_0000, 32'h0000_1234, "R2");
    check32(3'b001, 32'h0, 32'h0, "R2 R6");
    check32(3'b000, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R9");
    check32(3'b001, 32'h8000_0000, 32'h8000_0000, "R9");
  endtask

  task automatic t_add;
    check32(3'b010, 32'd5, 32'd7, "R3");
    check32(3'b010, 32'hFFFF_FFFF, 32'h1, "R3 R6");
    check32(3'b010, 32'h7FFF_FFFF, 32'h1, "R7");
    check32(3'b010, 32'h8000_0000, 32'h8000_0000, "R7");
    check32(3'b010, 32'h8000_0000, 32'h7FFF_FFFF, "R7");
  endtask

  task automatic t_sub;
    check32(3'b110, 32'd29, 32'd3, "R4");
    check32(3'b110, 32'd3, 32'd29, "R4");
    check32(3'b110, 32'h8000_0000, 32'h1, "R8");
    check32(3'b110, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R8");
    check32(3'b110, 32'hFFFF_FFFF, 32'h7FFF_FFFF, "R8");
    check32(3'b110, 32'h1234_5678, 32'h1234_5678, "R6");
    check32(3'b110, 32'h1234_5678, 32'h1234_5679, "R6");
  endtask

  task automatic t_slt;
    check32(3'b111, 32'hFFFF_FFFF, 32'h1, "R5");
    check32(3'b111, 32'h1, 32'hFFFF_FFFF, "R5");
    check32(3'b111, 32'h8000_0000, 32'h7FFF_FFFF, "R5");
    check32(3'b111, 32'h7FFF_FFFF, 32'h8000_0000, "R5");
    check32(3'b111, 32'd9, 32'd9, "R5 R9");
  endtask

  task automatic t_illegal;
    check32(3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10");
    check32(3'b100, 32'h7FFF_FFFF, 32'h8000_0000, "R10");
    check32(3'b101, 32'h8000_0000, 32'h1, "R10");
  endtask

  // R11: output follows a new input without any clock edge
  task automatic t_comb;
    @(negedge clk);
    op = 3'b010; a = 32'd10; b = 32'd20;
    #1;
    a = 32'd11;
    #1;
    checks++;
    if (res !== 32'd31) begin
      fails++;
      $display("FAIL R11 got res=%h exp res=%h", res, 32'd31);
    end
  endtask

  task automatic t_narrow_sweep;
    for (int o = 0; o < 8; o++) begin
      for (int x = 0; x < (1 << NW); x++) begin
        for (int y = 0; y < (1 << NW); y++) begin
          longint er;
          logic   ev;
          @(negedge clk);
          nop = 3'(o); na = NW'(x); nb = NW'(y);
          #1;
          model(NW, 3'(o), longint'(x), longint'(y), er, ev);
          checks++;
          if (nres !== NW'(er) || novf !== ev || nzero !== (er == 0)) begin
            fails++;
            $display("FAIL %s narrow op=%0d a=%0d b=%0d: got res=%0d ovf=%b zero=%b exp res=%0d ovf=%b zero=%b",
                     tag_of(3'(o)), o, x, y, nres, novf, nzero, er, ev, (er == 0));
          end
        end
      end
    end
  endtask

  initial begin
    op = '0; a = '0; b = '0;
    nop = '0; na = '0; nb = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
  end

  initial begin
    t_reset_state();
    t_logic();
    t_add();
    t_sub();
    t_slt();
    t_illegal();
    t_comb();
    t_narrow_sweep();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired: got running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule